// File: doc/BRIEF.md
# Holt Clock-Drift Compensator

This block turns a stream of per-cycle clock-drift measurements for one network node into a corrected clock offset that can be written back to that node. Each accepted sample carries the measured drift and the node's present offset. The block keeps a smoothed drift level and a drift slope. It predicts the next drift from them, limits the prediction to a programmable bound so that a bad sample cannot over-correct the clock, and subtracts the limited prediction from the present offset.

Software or a sequencer presents one sample per compensation period, typically once per millisecond. The first sample after reset or clear only seeds the level. The second sample seeds the slope and gives the first result. Every sample after that runs the full recursive update. The two smoothing weights are unsigned fractions. Their usual settings are about 0.9 for the level weight and 0.5 for the slope weight, and the bound is usually 5000 (ns).

Top module: `drift_holt_comp`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid` is 0. After reset the block is unseeded.
- R2: A sample accepted while the block is unseeded (the first sample after reset or clear) stores level = drift and produces no result: `out_valid` stays 0 in the following cycle.
- R3: The second accepted sample x2 sets the slope to x2 − level, where level is the first sample x1. The level stays at x1. The forecast for this sample is therefore x2.
- R4: Each later sample x updates the level to P + rnd(a·(x − P)), where P = old level + old slope. Here a = `alpha`/65536, and rnd(v) = floor(v + 1/2), computed as (weight·v + 32768) shifted arithmetically right by 16 in signed 48-bit arithmetic.
- R5: In the same update the slope becomes T + rnd(b·((L_new − L_old) − T)), where T is the old slope and b = `beta`/65536. The forecast is L_new + T_new.
- R6: `out_valid` is 1 for exactly one cycle, in the cycle after each accepted sample from the second one on. In every other cycle it is 0.
- R7: A forecast greater than `limit` is replaced by +`limit`. A forecast equal to `limit` passes unchanged.
- R8: A forecast less than −`limit` is replaced by −`limit`.
- R9: `clr` returns the block to the unseeded state. A sample presented in the same cycle as `clr` is discarded, and `out_valid` is 0 in the next cycle.
- R10: `out_offset` = `in_offset` − (limited forecast), using the offset carried by the same sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous return to the unseeded state |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_drift | input | DW (48) | Measured drift, signed |
| in_offset | input | DW (48) | Present clock offset, signed |
| alpha | input | FW (16) | Level weight, unsigned Q0.16 |
| beta | input | FW (16) | Slope weight, unsigned Q0.16 |
| limit | input | DW-1 (47) | Non-negative forecast bound |
| out_valid | output | 1 | Result strobe |
| out_offset | output | DW (48) | New offset for write-back, signed |

## Verification
A wrong level or slope does not stay hidden: it shows in the very next `out_offset`. It also keeps showing in every later result, because both values feed back into each forecast. The stimulus sequence therefore checks every result against values worked out by hand, including rounding of odd and negative differences. A wrong seeding phase shows as a result that appears one sample too early or too late. A bad bound shows as soon as a large swing in drift pushes the forecast past `limit` in either direction.

// File: rtl/holt_pkg.sv
package holt_pkg;
  typedef enum logic [1:0] {
    PH_EMPTY = 2'd0,
    PH_ONE   = 2'd1,
    PH_RUN   = 2'd2
  } holt_phase_t;
endpackage

// File: rtl/holt_round_mul.sv
module holt_round_mul #(
  parameter int DW = 48,
  parameter int FW = 16
) (
  input  logic [FW-1:0]        weight,
  input  logic signed [DW-1:0] value,
  output logic signed [DW-1:0] product
);
  localparam int PW = DW + FW + 1;
  localparam logic signed [PW-1:0] HALF = {{(PW-FW){1'b0}}, 1'b1, {(FW-1){1'b0}}};

  logic signed [PW-1:0] full;
  logic signed [PW-1:0] biased;
  logic signed [PW-1:0] shifted;

  always_comb begin
    full    = $signed({1'b0, weight}) * value;
    biased  = full + HALF;
    shifted = biased >>> FW;
    product = shifted[DW-1:0];
  end
endmodule

// File: rtl/holt_estimator.sv
module holt_estimator
  import holt_pkg::*;
#(
  parameter int DW = 48,
  parameter int FW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp_x,
  input  logic [FW-1:0]        wa,
  input  logic [FW-1:0]        wb,
  output logic signed [DW-1:0] fc_o,
  output logic                 fire_o,
  output logic                 primed_o
);
  holt_phase_t phase;
  logic signed [DW-1:0] lvl, trd;
  logic signed [DW-1:0] pred, err_l, adj_l, lvl_n;
  logic signed [DW-1:0] err_t, adj_t, trd_n;
  logic take;

  holt_round_mul #(.DW(DW), .FW(FW)) u_mul_lvl (.weight(wa), .value(err_l), .product(adj_l));
  holt_round_mul #(.DW(DW), .FW(FW)) u_mul_trd (.weight(wb), .value(err_t), .product(adj_t));

  always_comb begin
    take   = smp_vld && !clr;
    pred   = lvl + trd;
    err_l  = smp_x - pred;
    lvl_n  = pred + adj_l;
    err_t  = (lvl_n - lvl) - trd;
    trd_n  = trd + adj_t;
    fire_o = take && (phase != PH_EMPTY);
    fc_o   = (phase == PH_ONE) ? smp_x : (lvl_n + trd_n);
    primed_o = (phase != PH_EMPTY);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase <= PH_EMPTY;
      lvl   <= '0;
      trd   <= '0;
    end else if (take) begin
      unique case (phase)
        PH_EMPTY: begin
          lvl   <= smp_x;
          phase <= PH_ONE;
        end
        PH_ONE: begin
          trd   <= smp_x - lvl;
          phase <= PH_RUN;
        end
        default: begin
          lvl   <= lvl_n;
          trd   <= trd_n;
          phase <= PH_RUN;
        end
      endcase
    end
  end

  // R3
  seed_trend_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ONE && take) |=> (trd == $past(smp_x) - $past(lvl)) && (lvl == $past(lvl)));

  // R2
  seed_level_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EMPTY && take) |=> (lvl == $past(smp_x)) && (phase == PH_ONE));
endmodule

// File: rtl/holt_limit.sv
module holt_limit #(
  parameter int DW = 48
) (
  input  logic signed [DW-1:0] fc_in,
  input  logic [DW-2:0]        bound,
  output logic signed [DW-1:0] fc_out
);
  logic signed [DW-1:0] pos_b, neg_b;

  always_comb begin
    pos_b = $signed({1'b0, bound});
    neg_b = -pos_b;
    if (fc_in > pos_b)      fc_out = pos_b;
    else if (fc_in < neg_b) fc_out = neg_b;
    else                    fc_out = fc_in;
  end

  // R7 R8
  always_comb begin
    if (!$isunknown({fc_in, bound}))
      sat_bound_chk: assert (fc_out <= pos_b && fc_out >= neg_b);
  end
endmodule

// File: rtl/drift_holt_comp.sv
module drift_holt_comp #(
  parameter int DW = 48,
  parameter int FW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_drift,
  input  logic signed [DW-1:0] in_offset,
  input  logic [FW-1:0]        alpha,
  input  logic [FW-1:0]        beta,
  input  logic [DW-2:0]        limit,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_offset
);
  logic signed [DW-1:0] fc_raw, fc_lim;
  logic fire, primed;

  holt_estimator #(.DW(DW), .FW(FW)) u_est (
    .clk(clk), .rst(rst), .clr(clr),
    .smp_vld(in_valid), .smp_x(in_drift),
    .wa(alpha), .wb(beta),
    .fc_o(fc_raw), .fire_o(fire), .primed_o(primed)
  );

  holt_limit #(.DW(DW)) u_lim (
    .fc_in(fc_raw), .bound(limit), .fc_out(fc_lim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_offset <= in_offset - fc_lim;
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R9
  clr_quiet_chk: assert property (@(posedge clk) disable iff (rst) clr |=> !out_valid);

  // R6
  valid_src_chk: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(in_valid));

  // R2
  first_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!primed && in_valid) |=> !out_valid);
endmodule

// File: tb/test_drift_holt_comp.sv
module test_drift_holt_comp;
  localparam int DW = 48;
  localparam int FW = 16;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic signed [DW-1:0] x;
    logic signed [DW-1:0] off;
    logic                 vld;
    logic signed [DW-1:0] exp;
  } vec_t;

  // weights 0.5 / 0.5, bound 5000
  localparam vec_t VEC [7] = '{
    '{ 48'sd100,    48'sd1000, 1'b0, 48'sd0    },  // R2 seed level
    '{ 48'sd140,    48'sd2000, 1'b1, 48'sd1860 },  // R3 forecast = x2
    '{ 48'sd200,    48'sd3000, 1'b1, 48'sd2775 },  // R4 R5
    '{ 48'sd250,    48'sd4000, 1'b1, 48'sd3700 },  // R4 R5
    '{ -48'sd101,   48'sd0,    1'b1, -48'sd62  },  // R4 R5 negative rounding
    '{ 48'sd9000,   48'sd500,  1'b1, -48'sd4500},  // R7 upper clamp
    '{ -48'sd20000, 48'sd0,    1'b1, 48'sd5000 }   // R8 lower clamp
  };

  logic clk = 1'b0;
  logic rst, clr, in_valid;
  logic signed [DW-1:0] in_drift, in_offset;
  logic [FW-1:0] alpha, beta;
  logic [DW-2:0] limit;
  logic out_valid;
  logic signed [DW-1:0] out_offset;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drift_holt_comp #(.DW(DW), .FW(FW)) i_drift_holt_comp (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
    .in_drift(in_drift), .in_offset(in_offset),
    .alpha(alpha), .beta(beta), .limit(limit),
    .out_valid(out_valid), .out_offset(out_offset)
  );

  task automatic check(input string tag, input logic signed [DW-1:0] act, input logic signed [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic signed [DW-1:0] x, input logic signed [DW-1:0] off);
    @(negedge clk);
    in_valid = 1'b1; in_drift = x; in_offset = off;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    rst = 1'b1; clr = 1'b0; in_valid = 1'b0; in_drift = '0; in_offset = '0;
    alpha = 16'd32768; beta = 16'd32768; limit = 47'd5000;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {47'd0, out_valid}, 48'sd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {47'd0, out_valid}, 48'sd0);

    for (int i = 0; i < 7; i++) begin
      send(VEC[i].x, VEC[i].off);
      check($sformatf("R6 row %0d valid", i), {47'd0, out_valid}, {47'd0, VEC[i].vld});
      if (VEC[i].vld) check($sformatf("R10 row %0d offset", i), out_offset, VEC[i].exp);
      @(negedge clk);
      check($sformatf("R6 row %0d idle", i), {47'd0, out_valid}, 48'sd0);
    end

    // R9: sample together with clear is dropped
    @(negedge clk);
    clr = 1'b1; in_valid = 1'b1; in_drift = 48'sd777; in_offset = 48'sd0;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    check("R9 valid after clear", {47'd0, out_valid}, 48'sd0);
    send(48'sd10, 48'sd0);
    check("R9 R2 first sample after clear quiet", {47'd0, out_valid}, 48'sd0);
    send(48'sd30, 48'sd100);
    check("R3 second sample valid", {47'd0, out_valid}, 48'sd1);
    check("R3 second sample offset", out_offset, 48'sd70);

    // R4 R5 with level weight 0.9, R7 bound equality passes
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    send(48'sd0, 48'sd0);
    send(48'sd0, 48'sd0);
    check("R3 zero seed offset", out_offset, 48'sd0);
    alpha = 16'd58982; limit = 47'd1350;
    send(48'sd1000, 48'sd0);
    check("R4 R5 weighted valid", {47'd0, out_valid}, 48'sd1);
    check("R4 R5 R7 weighted offset", out_offset, -48'sd1350);

    done = 1'b1;
    finish_run();
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule